// File: doc/BRIEF.md
# DMA Request Sense and Bus Handoff Controller

This block decides, one clock at a time, whether a single DMA channel holds the bus or returns it to the CPU. It watches an external active-low request line, which can be set to act on its level or on its falling edge. While the channel owns the bus, each byte moves as a memory read cycle followed by a write cycle. Each cycle steps through T1 and T2, then zero or more wait states, then T3.

The request is looked at only once per byte. That happens on the clock edge that leaves the last T2 or wait state of the write cycle. In level mode the channel keeps the bus for another byte if the request is still low there. In edge mode it keeps the bus only if a fresh falling edge has arrived since the last one was used. A byte counter is loaded with a start count. The transfer-end output marks the byte during which the counter reads zero. After that byte the channel disables itself and gives the bus back, whatever the request does.

Software or a neighbouring block loads the count and enables the channel with a one-cycle load pulse. The bus arbiter then uses the bus-owner output, and the memory interface follows the cycle-state and phase outputs.

Top module: `dma_req_handoff`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_dma` is 0, `cyc_state` is 0 (idle) and `xfer_end` is 0.
- R2: `cyc_state` encodes idle=0, T1=1, T2=2, wait=3, T3=4, and `cyc_write` is 0 for the read cycle and 1 for the write cycle. A DMA byte always runs read T1, T2, [wait...], T3, then write T1, T2, [wait...], T3, and bus ownership always starts at read T1.
- R3: With `wait_ins`=1, each cycle in which `ready` is 0 during T2 or a wait state adds one wait state before T3. With `wait_ins`=0, `ready` has no effect and every cycle is exactly three states long.
- R4: In level mode (`edge_mode`=0), an enabled idle channel takes the bus when the synchronized request is low. If the request is high at the write-cycle sample point, the bus returns to the CPU after that byte.
- R5: In edge mode (`edge_mode`=1), a falling edge of `dreq_n` starts DMA. The channel goes on to another byte only if a new falling edge has been seen since the previous one was used, so a request held low yields a single byte.
- R6: In edge mode, once the CPU holds the bus it keeps it until a new falling edge arrives on `dreq_n`. That edge resumes transfers from the remaining count.
- R7: A `ch_load` pulse while idle loads `start_count` and enables the channel. A start count of N gives N+1 bytes, and `xfer_end` is 1 during all states of the byte for which the counter reads zero.
- R8: After the write T3 of the byte marked by `xfer_end`, the bus returns to the CPU and the channel stays disabled even with the request held active.
- R9: A channel that has not been loaded ignores the request and never takes the bus.
- R10: `dreq_n` passes through a two-flop synchronizer. A request driven low before rising edge k puts the bus in read T1 after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq_n | input | 1 | Asynchronous DMA request, active low |
| edge_mode | input | 1 | 1 = falling-edge sense, 0 = level sense |
| ch_load | input | 1 | One-cycle pulse: load count and enable channel (idle only) |
| start_count | input | 16 | Byte count to load; N gives N+1 bytes |
| wait_ins | input | 1 | 1 = honour `ready` for wait insertion |
| ready | input | 1 | Memory/I/O ready; 0 during T2 or wait requests a wait state |
| bus_dma | output | 1 | 1 = DMA owns the bus, 0 = CPU owns it |
| cyc_state | output | 3 | Machine state: 0 idle, 1 T1, 2 T2, 3 wait, 4 T3 |
| cyc_write | output | 1 | 0 = read cycle, 1 = write cycle |
| xfer_end | output | 1 | High throughout the final byte transfer |

## Verification
The bench targets several boundary cases.

- **Request held low in edge mode.** It must yield exactly one byte. A design that treated the low level as a new edge would keep the bus.
- **Request released during the read cycle in level mode.** It must stop after that byte. A design that sampled too late, or at the wrong cycle, would move an extra byte.
- **Edges repeated once per byte, with wait states.** These must keep the channel running right up to the count end. A sticky flag that was cleared early, or never set, would drop the bus after one byte.
- **Count exhaustion with the request still active.** It must leave the bus with the CPU. A counter that wrapped or kept the channel enabled would grab the bus again.
- **Zero start count.** It must still produce one byte.
- **`ready` held low with wait insertion off.** It must add no wait states.
- **Request timing.** The exact edge at which a request reaches the bus is pinned, so the synchronizer cannot lose or gain a stage.

// File: rtl/dma_hs_pkg.sv
// Shared machine-state encoding for the DMA request/handoff controller.
package dma_hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4
    } cyc_st_t;
endpackage

// File: rtl/dreq_sense.sv
// dreq_sense: brings the asynchronous active-low request into the clock
// domain and keeps a sticky record of falling edges for edge-sense mode.
// Assumes SYNC_STAGES >= 2. The sticky flag clears whenever the consumer
// uses the request (consume = 1); an edge seen in that same cycle is
// offered through want_edge and consumed together with the flag.
module dreq_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n,
    input  logic edge_mode,
    input  logic consume,
    output logic req_low,
    output logic want_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   fall;

    // Synchronizer chain; idle level of the line is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], dreq_n};
    end

    // Previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // High for one cycle after the synchronized line drops.
    always_comb fall = prev_q & ~sync_q[SYNC_STAGES-1];

    // Sticky falling-edge flag, edge mode only, cleared on use.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (consume)           flag_q <= 1'b0;
        else if (fall && edge_mode) flag_q <= 1'b1;
    end

    assign req_low   = ~sync_q[SYNC_STAGES-1];
    assign want_edge = flag_q | fall;
endmodule

// File: rtl/dma_byte_count.sv
// dma_byte_count: holds the remaining-byte counter and the channel enable.
// A load is accepted only while the sequencer is idle. A count of zero
// marks the last byte; finishing that byte drops the enable instead of
// decrementing, so the counter never wraps.
module dma_byte_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          idle,
    input  logic [CW-1:0] start_count,
    input  logic          wr_done,
    output logic          ch_en,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Count register: load when idle, step down after each written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load && idle)             cnt_q <= start_count;
        else if (wr_done && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Channel enable: set by load, cleared once the zero-count byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ch_en <= 1'b0;
        else if (load && idle)             ch_en <= 1'b1;
        else if (wr_done && cnt_q == '0)   ch_en <= 1'b0;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/dma_cycle_seq.sv
// dma_cycle_seq: walks the read and write machine cycles of each byte and
// decides at the write-cycle sample point whether another byte follows.
// Assumes req_low / want_edge are already synchronous. The sample point is
// the edge that leaves T2 or the last wait state of the write cycle.
module dma_cycle_seq
    import dma_hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ch_en,
    input  logic    last,
    input  logic    edge_mode,
    input  logic    req_low,
    input  logic    want_edge,
    input  logic    wait_ins,
    input  logic    ready,
    output cyc_st_t state,
    output logic    wr_phase,
    output logic    take_req,
    output logic    wr_done
);
    cyc_st_t state_d;
    logic    wr_d;
    logic    keep_q;
    logic    req_ok;
    logic    start;
    logic    stretch;
    logic    sample;

    // Request qualification and per-cycle decision terms.
    always_comb begin
        req_ok   = edge_mode ? want_edge : req_low;
        start    = (state == ST_IDLE) && ch_en && req_ok;
        stretch  = wait_ins && !ready;
        sample   = ((state == ST_T2) || (state == ST_TW)) && wr_phase && !stretch;
        take_req = start | sample;
        wr_done  = (state == ST_T3) && wr_phase;
    end

    // Next-state and next-phase selection.
    always_comb begin
        state_d = state;
        wr_d    = wr_phase;
        case (state)
            ST_IDLE: if (start) begin state_d = ST_T1; wr_d = 1'b0; end
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = stretch ? ST_TW : ST_T3;
            ST_TW:   state_d = stretch ? ST_TW : ST_T3;
            ST_T3: begin
                if (!wr_phase) begin
                    state_d = ST_T1;
                    wr_d    = 1'b1;
                end else if (keep_q && !last) begin
                    state_d = ST_T1;
                    wr_d    = 1'b0;
                end else begin
                    state_d = ST_IDLE;
                    wr_d    = 1'b0;
                end
            end
            default: begin state_d = ST_IDLE; wr_d = 1'b0; end
        endcase
    end

    // State and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wr_phase <= 1'b0;
        end else begin
            state    <= state_d;
            wr_phase <= wr_d;
        end
    end

    // Continue decision captured at the write-cycle sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)      keep_q <= 1'b0;
        else if (sample) keep_q <= req_ok;
    end
endmodule

// File: rtl/dma_req_handoff.sv
// dma_req_handoff: top of the DMA request sense and bus handoff controller.
// Ties the request synchronizer, the byte counter and the cycle sequencer
// together. Assumes one channel, one byte per read/write cycle pair.
module dma_req_handoff
    import dma_hs_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dreq_n,
    input  logic          edge_mode,
    input  logic          ch_load,
    input  logic [CW-1:0] start_count,
    input  logic          wait_ins,
    input  logic          ready,
    output logic          bus_dma,
    output logic [2:0]    cyc_state,
    output logic          cyc_write,
    output logic          xfer_end
);
    cyc_st_t state;
    logic    wr_phase;
    logic    take_req;
    logic    wr_done;
    logic    req_low;
    logic    want_edge;
    logic    ch_en;
    logic    last;
    logic    idle;

    assign idle = (state == ST_IDLE);

    dreq_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq_n    (dreq_n),
        .edge_mode (edge_mode),
        .consume   (take_req),
        .req_low   (req_low),
        .want_edge (want_edge)
    );

    dma_byte_count #(.CW(CW)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ch_load),
        .idle        (idle),
        .start_count (start_count),
        .wr_done     (wr_done),
        .ch_en       (ch_en),
        .last        (last)
    );

    dma_cycle_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .last      (last),
        .edge_mode (edge_mode),
        .req_low   (req_low),
        .want_edge (want_edge),
        .wait_ins  (wait_ins),
        .ready     (ready),
        .state     (state),
        .wr_phase  (wr_phase),
        .take_req  (take_req),
        .wr_done   (wr_done)
    );

    // Output mapping: bus owner, state code, phase, last-byte marker.
    always_comb begin
        bus_dma   = !idle;
        cyc_state = state;
        cyc_write = wr_phase;
        xfer_end  = !idle && last;
    end
endmodule

// File: rtl/dma_req_handoff_chk.sv
// dma_req_handoff_chk: protocol checker for the handoff controller,
// observing only the top-level ports. Attached by the bind below.
module dma_req_handoff_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wait_ins,
    input logic       ready,
    input logic       bus_dma,
    input logic [2:0] cyc_state,
    input logic       cyc_write,
    input logic       xfer_end
);
    localparam logic [2:0] S_T1 = 3'd1;
    localparam logic [2:0] S_T2 = 3'd2;
    localparam logic [2:0] S_TW = 3'd3;
    localparam logic [2:0] S_T3 = 3'd4;

    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_state == S_T1 |=> cyc_state == S_T2); // R2
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == S_T3 && !cyc_write) |=> (cyc_state == S_T1 && cyc_write)); // R2
    AST_GRANT_AT_READ_T1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dma) |-> (cyc_state == S_T1 && !cyc_write)); // R2
    AST_NO_WAIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_state == S_T2 || cyc_state == S_TW) && !wait_ins) |=> cyc_state == S_T3); // R3
    AST_WAIT_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_state == S_T2 || cyc_state == S_TW) && wait_ins && !ready) |=> cyc_state == S_TW); // R3
    AST_TEND_ONLY_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |-> bus_dma); // R7
    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == S_T3 && cyc_write && xfer_end) |=> !bus_dma); // R8
endmodule

bind dma_req_handoff dma_req_handoff_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_ins  (wait_ins),
    .ready     (ready),
    .bus_dma   (bus_dma),
    .cyc_state (cyc_state),
    .cyc_write (cyc_write),
    .xfer_end  (xfer_end)
);

// File: tb/dma_req_handoff_bench.sv
module dma_req_handoff_bench;
    localparam int PAT_HOLD   = 0;
    localparam int PAT_SINGLE = 1;
    localparam int PAT_PULSE  = 2;

    typedef struct packed {
        logic        em;
        logic        wi;
        logic [3:0]  nw;
        logic [1:0]  pat;
        logic [15:0] cnt;
        logic [7:0]  xf;
    } vec_t;

    // edge_mode, wait_ins, ready-low cycles, pattern, start count, expected bytes
    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 4'd0, 2'd0, 16'd3, 8'd4},
        '{1'b0, 1'b0, 4'd0, 2'd0, 16'd0, 8'd1},
        '{1'b1, 1'b0, 4'd0, 2'd1, 16'd5, 8'd1},
        '{1'b1, 1'b0, 4'd0, 2'd0, 16'd5, 8'd1},
        '{1'b0, 1'b1, 4'd2, 2'd0, 16'd1, 8'd2},
        '{1'b0, 1'b0, 4'd2, 2'd0, 16'd1, 8'd2},
        '{1'b1, 1'b1, 4'd1, 2'd2, 16'd2, 8'd3},
        '{1'b1, 1'b0, 4'd0, 2'd2, 16'd4, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dreq_n = 1'b1;
    logic        edge_mode = 1'b0;
    logic        ch_load = 1'b0;
    logic [15:0] start_count = '0;
    logic        wait_ins = 1'b0;
    logic        ready = 1'b1;
    logic        bus_dma;
    logic [2:0]  cyc_state;
    logic        cyc_write;
    logic        xfer_end;

    int checks = 0;
    int fails = 0;
    int nwait_cur = 0;
    int waited = 0;
    int wr_cnt, te_cnt, bus_cyc;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_req_handoff u_dma_req_handoff (
        .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .edge_mode(edge_mode),
        .ch_load(ch_load), .start_count(start_count), .wait_ins(wait_ins),
        .ready(ready), .bus_dma(bus_dma), .cyc_state(cyc_state),
        .cyc_write(cyc_write), .xfer_end(xfer_end)
    );

    // Ready driver: holds ready low for nwait_cur cycles of each T2/wait stretch.
    always @(negedge clk) begin
        if ((cyc_state == 3'd2 || cyc_state == 3'd3) && waited < nwait_cur) begin
            ready = 1'b0;
            waited++;
        end else begin
            ready = 1'b1;
        end
        if (cyc_state == 3'd4) waited = 0;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dreq_n = 1'b1; ch_load = 1'b0; nwait_cur = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_load(input logic [15:0] n);
        @(negedge clk);
        ch_load = 1'b1; start_count = n;
        @(negedge clk);
        ch_load = 1'b0;
    endtask

    // Observe n cycles, driving the request per pattern.
    task automatic run_window(input int n, input int pat);
        int pcnt = 0;
        wr_cnt = 0; te_cnt = 0; bus_cyc = 0;
        if (pat != PAT_HOLD) begin dreq_n = 1'b0; pcnt = 2; end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cyc_state == 3'd4 && cyc_write) wr_cnt++;
            if (xfer_end) te_cnt++;
            if (bus_dma) bus_cyc++;
            if (pcnt > 0) begin
                pcnt--;
                if (pcnt == 0) dreq_n = 1'b1;
            end
            if (pat == PAT_PULSE && cyc_state == 3'd1 && !cyc_write) begin
                dreq_n = 1'b0; pcnt = 2;
            end
        end
    endtask

    initial begin
        // R1: reset state, with the request active during reset
        rst_n = 1'b0; dreq_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 bus_dma in reset", int'(bus_dma), 0);
        chk("R1 cyc_state in reset", int'(cyc_state), 0);
        chk("R1 xfer_end in reset", int'(xfer_end), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus_dma after reset", int'(bus_dma), 0);

        // Vector table walk
        for (int v = 0; v < 8; v++) begin
            int weff, exp_bus, exp_te;
            do_reset();
            edge_mode = VEC[v].em; wait_ins = VEC[v].wi; nwait_cur = int'(VEC[v].nw);
            do_load(VEC[v].cnt);
            if (VEC[v].pat == PAT_HOLD) dreq_n = 1'b0;
            run_window(200, int'(VEC[v].pat));
            weff    = VEC[v].wi ? int'(VEC[v].nw) : 0;
            exp_bus = int'(VEC[v].xf) * 2 * (3 + weff);
            exp_te  = (int'(VEC[v].xf) == int'(VEC[v].cnt) + 1) ? 2 * (3 + weff) : 0;
            chk($sformatf("R4/R5/R7 vec%0d bytes", v), wr_cnt, int'(VEC[v].xf));
            chk($sformatf("R2/R3 vec%0d bus cycles", v), bus_cyc, exp_bus);
            chk($sformatf("R7 vec%0d xfer_end cycles", v), te_cnt, exp_te);
            chk($sformatf("R8 vec%0d bus idle at end", v), int'(bus_dma), 0);
            dreq_n = 1'b1;
        end

        // R9: unloaded channel ignores the request
        do_reset();
        edge_mode = 1'b0; wait_ins = 1'b0;
        dreq_n = 1'b0;
        run_window(40, PAT_HOLD);
        chk("R9 unloaded bus cycles", bus_cyc, 0);
        dreq_n = 1'b1;

        // R10: latency through the synchronizer; R2 entry state
        do_reset();
        edge_mode = 1'b0;
        do_load(16'd9);
        @(negedge clk);
        dreq_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R10 bus_dma after two edges", int'(bus_dma), 0);
        @(posedge clk); #1;
        chk("R10 bus_dma after third edge", int'(bus_dma), 1);
        chk("R2 entry cyc_state T1", int'(cyc_state), 1);
        chk("R2 entry cyc_write read", int'(cyc_write), 0);

        // R4: level request released during the read cycle -> one byte
        @(negedge clk);
        dreq_n = 1'b1;
        run_window(60, PAT_HOLD);
        chk("R4 level release bytes", wr_cnt, 1);
        chk("R4 level release bus idle", int'(bus_dma), 0);
        // R7/R8: resume from the remaining count until exhausted
        dreq_n = 1'b0;
        run_window(200, PAT_HOLD);
        chk("R7 resumed bytes", wr_cnt, 9);
        chk("R7 resumed xfer_end cycles", te_cnt, 6);
        chk("R8 held request after end", bus_cyc, 54);
        dreq_n = 1'b1;

        // R6: edge mode, CPU keeps bus until a new fall
        do_reset();
        edge_mode = 1'b1; wait_ins = 1'b0;
        do_load(16'd5);
        run_window(40, PAT_SINGLE);
        chk("R5 single edge bytes", wr_cnt, 1);
        run_window(60, PAT_HOLD);
        chk("R6 no edge keeps CPU", bus_cyc, 0);
        run_window(40, PAT_SINGLE);
        chk("R6 new edge resumes bytes", wr_cnt, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule